// File: doc/BRIEF.md
# Processor Mode and Banked Register Unit

This unit keeps a processor core's 8-bit status word and the per-mode copies of the stack pointer, the link register and the saved status word. The status word has three flags (IRQ mask in bit 7, fast-interrupt mask in bit 6, Thumb enable in bit 5) and a five-bit mode field in bits 4:0. The mode field is the state of the unit's state machine. It picks which physical SP, LR and saved status word the register ports see. Registers R0 to R12 form one set that all modes share. Reads of R15 return the address of the first instruction not yet executed.

The unit performs three events. IRQ entry saves the status word, enters IRQ mode, masks IRQs, loads the IRQ link register with the resume address plus 4, and sends fetch to 0x18. Exception return copies the current mode's saved status word back into the status word and sends fetch to that mode's LR minus 4. A port write updates a register or a status word. Mode encodings: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111. Decode, the ALU and the other exception kinds are outside this unit.

States are the seven modes. The transitions are:
- IRQ_ENTRY: any mode goes to IRQ.
- RETURN: an exception mode goes to the mode held in its saved status word.
- STATUS_WRITE: any mode goes to the mode that is written.
- HOLD: no change.

Top module: `core_mode_bank`

## Requirements
- R1: After reset the status word reads 0xD3. This is Supervisor mode 10011, with the IRQ and fast-interrupt masks at 1 and Thumb at 0. No redirect is issued.
- R2: Registers 0 to 12 are one shared set. A value written in one mode reads back unchanged in every other mode.
- R3: Register 13 (SP) and register 14 (LR) have one copy for each of User, FIQ, IRQ, Supervisor, Abort and Undefined. System mode uses the User copy.
- R4: An IRQ request is taken only while status bit 7 is 0. A request made while bit 7 is 1 changes no mode and issues no redirect.
- R5: Taking an IRQ redirects fetch to 0x18 in the same cycle. On the next cycle the mode is IRQ, bit 7 is 1, bits 6:5 are unchanged, and the IRQ saved status word holds the previous status word.
- R6: Taking an IRQ loads the IRQ-mode LR with the first unexecuted address plus 4.
- R7: A return command in an exception mode redirects fetch to that mode's LR minus 4 in the same cycle. On the next cycle the status word equals that mode's saved status word. In User or System mode the command is ignored.
- R8: Nested transitions unwind in order. One example is User to IRQ, then a status write to Supervisor, then a return to IRQ, then a return to User.
- R9: Status select 0 addresses the status word and select 1 addresses the current mode's saved status word. In User and System mode the saved status word reads 0 and writes to it are dropped.
- R10: A status write or restore whose mode field is not one of the seven encodings leaves the mode unchanged, while bits 7:5 still take the written value.
- R11: IRQ entry has priority over a return, and a return has priority over port writes to SP, LR, status words and R15. Any port write that is overruled is dropped. A write to R15 alone redirects fetch to the written value.
- R12: Reading register 15 returns the first-unexecuted-address input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 4 | Register number to read |
| rd_data | output | 32 | Read data for rd_addr in the current mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| psr_rd_sel | input | 1 | 0 reads the status word, 1 reads the saved status word |
| psr_rd_data | output | 8 | Selected status word |
| psr_wr_en | input | 1 | Status write strobe |
| psr_wr_sel | input | 1 | 0 writes the status word, 1 writes the saved status word |
| psr_wr_data | input | 8 | Status write data |
| irq_req | input | 1 | IRQ request level |
| next_pc | input | 32 | Address of the first instruction not yet executed |
| eret | input | 1 | Exception return command |
| cur_mode | output | 5 | Current mode encoding |
| irq_masked | output | 1 | Status bit 7 |
| fiq_masked | output | 1 | Status bit 6 |
| thumb_en | output | 1 | Status bit 5 |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
A wrong mode state shows at the ports on the cycle after the event that caused it. The register ports then read the wrong SP, LR or saved status word, and cur_mode differs from the value the bench has tracked. Errors in bank selection stay hidden until the stored value is read back in its mode. For that reason each bank is written in one mode and read again after several transitions. Redirect faults show in the same cycle as the IRQ or return, so they are sampled in that cycle.

// File: rtl/mode_bank_pkg.sv
package mode_bank_pkg;
    localparam int PSR_W   = 8;
    localparam int MODE_W  = 5;
    localparam int N_BANK  = 6;
    localparam int BANK_W  = $clog2(N_BANK);
    localparam int IRQ_BIT = 7;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } cpu_mode_e;

    typedef enum logic [1:0] {
        EV_HOLD,
        EV_IRQ_ENTRY,
        EV_RETURN,
        EV_STATUS_WRITE
    } mode_ev_e;

    localparam logic [BANK_W-1:0] IRQ_BANK = BANK_W'(2);

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND) || (m == M_SYS);
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input cpu_mode_e m);
        logic [BANK_W-1:0] b;
        unique case (m)
            M_FIQ:   b = BANK_W'(1);
            M_IRQ:   b = BANK_W'(2);
            M_SVC:   b = BANK_W'(3);
            M_ABT:   b = BANK_W'(4);
            M_UND:   b = BANK_W'(5);
            default: b = BANK_W'(0);
        endcase
        return b;
    endfunction

    function automatic logic has_saved(input cpu_mode_e m);
        return (m != M_USR) && (m != M_SYS);
    endfunction
endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
    import mode_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_take,
    input  logic             ret_take,
    input  logic             cpsr_wr,
    input  logic [PSR_W-1:0] restore_psr,
    input  logic [PSR_W-1:0] cpsr_wdata,
    output logic [PSR_W-1:0] cpsr,
    output cpu_mode_e        mode
);
    localparam int FLAG_W = PSR_W - MODE_W;
    localparam logic [FLAG_W-1:0] FLAGS_RST = FLAG_W'(3'b110);

    cpu_mode_e         mode_q, mode_d;
    logic [FLAG_W-1:0] flags_q, flags_d;
    mode_ev_e          ev;

    always_comb begin
        if (irq_take)      ev = EV_IRQ_ENTRY;
        else if (ret_take) ev = EV_RETURN;
        else if (cpsr_wr)  ev = EV_STATUS_WRITE;
        else               ev = EV_HOLD;
    end

    always_comb begin
        mode_d  = mode_q;
        flags_d = flags_q;
        unique case (ev)
            EV_IRQ_ENTRY: begin
                mode_d  = M_IRQ;
                flags_d = {1'b1, flags_q[FLAG_W-2:0]};
            end
            EV_RETURN: begin
                flags_d = restore_psr[PSR_W-1:MODE_W];
                if (mode_legal(restore_psr[MODE_W-1:0]))
                    mode_d = cpu_mode_e'(restore_psr[MODE_W-1:0]);
            end
            EV_STATUS_WRITE: begin
                flags_d = cpsr_wdata[PSR_W-1:MODE_W];
                if (mode_legal(cpsr_wdata[MODE_W-1:0]))
                    mode_d = cpu_mode_e'(cpsr_wdata[MODE_W-1:0]);
            end
            EV_HOLD: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_SVC;
            flags_q <= FLAGS_RST;
        end else begin
            mode_q  <= mode_d;
            flags_q <= flags_d;
        end
    end

    always_comb begin
        cpsr = {flags_q, mode_q};
        mode = mode_q;
    end
endmodule

// File: rtl/banked_regs.sv
module banked_regs
    import mode_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_idx,
    input  logic              sp_we,
    input  logic              lr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              spsr_we,
    input  logic [PSR_W-1:0]  spsr_wdata,
    input  logic              irq_entry,
    input  logic [DATA_W-1:0] irq_lr,
    input  logic [PSR_W-1:0]  irq_spsr,
    output logic [DATA_W-1:0] sp_rd,
    output logic [DATA_W-1:0] lr_rd,
    output logic [PSR_W-1:0]  spsr_rd
);
    logic [DATA_W-1:0] sp_view   [N_BANK];
    logic [DATA_W-1:0] lr_view   [N_BANK];
    logic [PSR_W-1:0]  spsr_view [N_BANK];

    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        localparam logic [BANK_W-1:0] IDX = BANK_W'(g);
        logic [DATA_W-1:0] sp_q, lr_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_q <= '0;
                lr_q <= '0;
            end else begin
                if (sp_we && bank_idx == IDX) sp_q <= wdata;
                if (irq_entry && IDX == IRQ_BANK) lr_q <= irq_lr;
                else if (lr_we && bank_idx == IDX) lr_q <= wdata;
            end
        end
        assign sp_view[g] = sp_q;
        assign lr_view[g] = lr_q;

        if (g == 0) begin : g_nosaved
            assign spsr_view[g] = '0;
        end else begin : g_saved
            logic [PSR_W-1:0] spsr_q;
            always_ff @(posedge clk) begin
                if (!rst_n) spsr_q <= '0;
                else if (irq_entry && IDX == IRQ_BANK) spsr_q <= irq_spsr;
                else if (spsr_we && bank_idx == IDX) spsr_q <= spsr_wdata;
            end
            assign spsr_view[g] = spsr_q;
        end
    end

    always_comb begin
        sp_rd   = sp_view[bank_idx];
        lr_rd   = lr_view[bank_idx];
        spsr_rd = spsr_view[bank_idx];
    end
endmodule

// File: rtl/shared_regs.sv
module shared_regs #(
    parameter int DATA_W = 32,
    parameter int N_REG  = 13,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [N_REG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) regs_q[i] <= '0;
        end else if (we && int'(waddr) < N_REG) begin
            regs_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REG; i++)
            if (int'(raddr) == i) rdata = regs_q[i];
    end
endmodule

// File: rtl/core_mode_bank.sv
module core_mode_bank
    import mode_bank_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 4,
    parameter int          N_GPR   = 13,
    parameter logic [31:0] IRQ_VEC = 32'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              psr_rd_sel,
    output logic [7:0]        psr_rd_data,
    input  logic              psr_wr_en,
    input  logic              psr_wr_sel,
    input  logic [7:0]        psr_wr_data,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] next_pc,
    input  logic              eret,
    output logic [4:0]        cur_mode,
    output logic              irq_masked,
    output logic              fiq_masked,
    output logic              thumb_en,
    output logic              redirect_valid,
    output logic [DATA_W-1:0] redirect_pc
);
    localparam logic [ADDR_W-1:0] SP_NUM = ADDR_W'(N_GPR);
    localparam logic [ADDR_W-1:0] LR_NUM = ADDR_W'(N_GPR + 1);
    localparam logic [ADDR_W-1:0] PC_NUM = ADDR_W'(N_GPR + 2);
    localparam logic [DATA_W-1:0] LR_ADJ = DATA_W'(4);

    logic [PSR_W-1:0]  cpsr, spsr_rd;
    cpu_mode_e         mode;
    logic [DATA_W-1:0] sp_rd, lr_rd, gpr_rd;
    logic              irq_take, ret_take, port_ok;
    logic              sp_we, lr_we, cpsr_wr, spsr_we, pc_wr;

    always_comb begin
        irq_take = irq_req && !cpsr[IRQ_BIT];
        ret_take = eret && has_saved(mode) && !irq_take;
        port_ok  = !irq_take && !ret_take;
        sp_we    = wr_en && wr_addr == SP_NUM && port_ok;
        lr_we    = wr_en && wr_addr == LR_NUM && port_ok;
        pc_wr    = wr_en && wr_addr == PC_NUM && port_ok;
        cpsr_wr  = psr_wr_en && !psr_wr_sel && port_ok;
        spsr_we  = psr_wr_en && psr_wr_sel && has_saved(mode) && port_ok;
    end

    mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_take    (irq_take),
        .ret_take    (ret_take),
        .cpsr_wr     (cpsr_wr),
        .restore_psr (spsr_rd),
        .cpsr_wdata  (psr_wr_data),
        .cpsr        (cpsr),
        .mode        (mode)
    );

    banked_regs #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_idx   (bank_of(mode)),
        .sp_we      (sp_we),
        .lr_we      (lr_we),
        .wdata      (wr_data),
        .spsr_we    (spsr_we),
        .spsr_wdata (psr_wr_data),
        .irq_entry  (irq_take),
        .irq_lr     (next_pc + LR_ADJ),
        .irq_spsr   (cpsr),
        .sp_rd      (sp_rd),
        .lr_rd      (lr_rd),
        .spsr_rd    (spsr_rd)
    );

    shared_regs #(.DATA_W(DATA_W), .N_REG(N_GPR), .ADDR_W(ADDR_W)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (gpr_rd)
    );

    always_comb begin
        if (rd_addr == SP_NUM)      rd_data = sp_rd;
        else if (rd_addr == LR_NUM) rd_data = lr_rd;
        else if (rd_addr == PC_NUM) rd_data = next_pc;
        else                        rd_data = gpr_rd;

        psr_rd_data = psr_rd_sel ? spsr_rd : cpsr;
        cur_mode    = mode;
        irq_masked  = cpsr[7];
        fiq_masked  = cpsr[6];
        thumb_en    = cpsr[5];

        redirect_valid = irq_take || ret_take || pc_wr;
        if (irq_take)      redirect_pc = IRQ_VEC[DATA_W-1:0];
        else if (ret_take) redirect_pc = lr_rd - LR_ADJ;
        else if (pc_wr)    redirect_pc = wr_data;
        else               redirect_pc = '0;
    end
endmodule

// File: rtl/mode_bank_chk.sv
module mode_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  rd_addr,
    input logic [31:0] rd_data,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic        psr_wr_en,
    input logic        irq_req,
    input logic [31:0] next_pc,
    input logic        eret,
    input logic [4:0]  cur_mode,
    input logic        irq_masked,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc
);
    logic irq_go;
    assign irq_go = irq_req && !irq_masked;

    assert_irq_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_go |-> (redirect_valid && redirect_pc == 32'h18));

    assert_irq_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_go |=> (cur_mode == 5'b10010 && irq_masked));

    assert_irq_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_go |=> (rd_addr != 4'd14 || rd_data == $past(next_pc) + 32'd4));

    assert_masked_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_masked && !eret && !psr_wr_en) |=> $stable(cur_mode));

    assert_user_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !irq_go && !wr_en && (cur_mode == 5'b10000 || cur_mode == 5'b11111))
        |-> !redirect_valid);

    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 5'b10000 || cur_mode == 5'b10001 || cur_mode == 5'b10010 ||
         cur_mode == 5'b10011 || cur_mode == 5'b10111 || cur_mode == 5'b11011 ||
         cur_mode == 5'b11111));

    assert_pc_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 4'd15) |-> (rd_data == next_pc));
endmodule

bind core_mode_bank mode_bank_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .psr_wr_en      (psr_wr_en),
    .irq_req        (irq_req),
    .next_pc        (next_pc),
    .eret           (eret),
    .cur_mode       (cur_mode),
    .irq_masked     (irq_masked),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
);

// File: tb/sim_core_mode_bank.sv
`timescale 1ns/1ps
module sim_core_mode_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        psr_rd_sel = 1'b0;
    logic [7:0]  psr_rd_data;
    logic        psr_wr_en = 1'b0;
    logic        psr_wr_sel = 1'b0;
    logic [7:0]  psr_wr_data = '0;
    logic        irq_req = 1'b0;
    logic [31:0] next_pc = '0;
    logic        eret = 1'b0;
    logic [4:0]  cur_mode;
    logic        irq_masked, fiq_masked, thumb_en;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    always #4 clk = ~clk;

    core_mode_bank u0 (.*);

    localparam int K_RD = 0, K_PSR = 1, K_MODE = 2, K_REDIR = 3, K_NOREDIR = 4, K_FLAGS = 5;
    typedef struct {
        int          kind;
        logic [32:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [32:0] act;
            it = sbq.pop_front();
            case (it.kind)
                K_RD:    act = {1'b0, rd_data};
                K_PSR:   act = {25'b0, psr_rd_data};
                K_MODE:  act = {28'b0, cur_mode};
                K_REDIR: act = {redirect_valid, redirect_pc};
                K_FLAGS: act = {30'b0, irq_masked, fiq_masked, thumb_en};
                default: act = {redirect_valid, 32'b0};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        irq_req = 1'b0; eret = 1'b0; wr_en = 1'b0; psr_wr_en = 1'b0;
    endtask

    task automatic push(input int kind, input logic [32:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] v, input string tag);
        rd_addr = a;
        push(K_RD, {1'b0, v}, tag);
    endtask

    task automatic exp_psr(input logic sel, input logic [7:0] v, input string tag);
        psr_rd_sel = sel;
        push(K_PSR, {25'b0, v}, tag);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
    endtask

    task automatic wpsr(input logic sel, input logic [7:0] v);
        psr_wr_en = 1'b1; psr_wr_sel = sel; psr_wr_data = v;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        push(K_MODE, 33'h13, "R1");
        exp_psr(1'b0, 8'hD3, "R1");
        push(K_FLAGS, 33'd6, "R1");
        push(K_NOREDIR, 33'd0, "R1");
        wreg(4'd3, 32'hA5A5_0003);
        tick(); wreg(4'd13, 32'h1000);
        tick(); wreg(4'd14, 32'h2000);
        tick(); wpsr(1'b0, 8'h10);
        tick();
        push(K_MODE, 33'h10, "R1");
        exp_rd(4'd3, 32'hA5A5_0003, "R2");
        tick(); exp_rd(4'd13, 32'h0, "R3");
        wreg(4'd13, 32'h3000);
        tick(); wreg(4'd14, 32'h4444);
        exp_psr(1'b1, 8'h00, "R9");
        wpsr(1'b1, 8'h55);
        tick(); exp_psr(1'b1, 8'h00, "R9");
        wpsr(1'b0, 8'h1F);
        tick(); exp_rd(4'd13, 32'h3000, "R3");
        push(K_MODE, 33'h1F, "R3");
        wpsr(1'b0, 8'h95);
        tick();
        push(K_MODE, 33'h1F, "R10");
        exp_psr(1'b0, 8'h9F, "R10");
        wpsr(1'b0, 8'h10);
        tick();
        wpsr(1'b0, 8'h95);
        tick();
        push(K_MODE, 33'h10, "R10");
        exp_psr(1'b0, 8'h90, "R10");
        irq_req = 1'b1; next_pc = 32'h120;
        push(K_NOREDIR, 33'd0, "R4");
        tick();
        push(K_MODE, 33'h10, "R4");
        wpsr(1'b0, 8'h10);
        tick();
        irq_req = 1'b1;
        push(K_REDIR, {1'b1, 32'h18}, "R5");
        tick();
        push(K_MODE, 33'h12, "R5");
        exp_psr(1'b0, 8'h92, "R5");
        tick(); exp_psr(1'b1, 8'h10, "R5");
        exp_rd(4'd14, 32'h124, "R6");
        tick(); exp_rd(4'd13, 32'h0, "R3");
        irq_req = 1'b1;
        push(K_NOREDIR, 33'd0, "R4");
        tick(); exp_rd(4'd3, 32'hA5A5_0003, "R2");
        wpsr(1'b0, 8'h93);
        tick(); exp_rd(4'd13, 32'h1000, "R3");
        wpsr(1'b1, 8'h92);
        tick(); exp_psr(1'b1, 8'h92, "R9");
        wreg(4'd14, 32'h500);
        tick();
        eret = 1'b1;
        push(K_REDIR, {1'b1, 32'h4FC}, "R7");
        tick();
        push(K_MODE, 33'h12, "R8");
        exp_psr(1'b0, 8'h92, "R8");
        eret = 1'b1;
        push(K_REDIR, {1'b1, 32'h120}, "R7");
        tick();
        push(K_MODE, 33'h10, "R8");
        exp_psr(1'b0, 8'h10, "R8");
        tick(); exp_rd(4'd14, 32'h4444, "R8");
        eret = 1'b1;
        push(K_NOREDIR, 33'd0, "R7");
        tick();
        push(K_MODE, 33'h10, "R7");
        irq_req = 1'b1; eret = 1'b1; next_pc = 32'h200;
        wpsr(1'b0, 8'h1F);
        wreg(4'd13, 32'hDEAD);
        push(K_REDIR, {1'b1, 32'h18}, "R11");
        tick();
        push(K_MODE, 33'h12, "R11");
        exp_psr(1'b1, 8'h10, "R11");
        tick(); exp_rd(4'd14, 32'h204, "R6");
        eret = 1'b1;
        wreg(4'd15, 32'h777);
        push(K_REDIR, {1'b1, 32'h200}, "R11");
        tick();
        push(K_MODE, 33'h10, "R11");
        exp_rd(4'd13, 32'h3000, "R11");
        tick();
        wreg(4'd15, 32'h800);
        push(K_REDIR, {1'b1, 32'h800}, "R11");
        tick();
        next_pc = 32'h1234;
        exp_rd(4'd15, 32'h1234, "R12");
        tick();
        tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule